// File: doc/BRIEF.md
# Double-Buffered SPI Slave Controller

This block is a byte-wide SPI slave that sits behind a simple register-style host port. The host loads a byte to transmit, reads the byte received last, and reads and clears three sticky status flags. An external master drives the serial clock. The block samples that clock, the data input and the select input with a faster system clock through a two-flop synchroniser. It finds clock edges in the system clock domain. A polarity bit and a phase bit select any of the four usual SPI clock modes. Bits travel most significant first.

A one-deep transmit buffer sits in front of the transmit shift register, and a one-deep receive buffer sits behind the receive shift register. If the host writes while the transmit buffer is still occupied, the write is rejected and a collision flag is raised. If a byte completes while the previous one is still unread, the new byte is dropped and an overrun flag is raised. In 4-wire mode the block works only while its active-low select is low, and each falling edge of select restarts the bit count. In 3-wire mode the select is ignored, and the only way to realign the bit count is to drop and raise the enable.

Top module: `spi_slave_dbuf`

## Requirements
- R1: After 8 sampling SCK edges the 8 bits sampled from MOSI (first bit in bit 7) appear on `rd_data`, `rx_valid` goes to 1 and `flag_done` goes to 1.
- R2: With `cpol` giving the idle SCK level and `cpha`=0 sampling on the leading edge or `cpha`=1 sampling on the trailing edge, bytes are received and sent correctly in all four combinations.
- R3: A host write lands in the transmit buffer. It moves at once into an empty shift register, or else after the last SCK edge of the byte in progress. MISO sends the shift register MSB first, and with `cpha`=0 bit 7 is already on MISO before the first SCK edge.
- R4: A host write while the transmit buffer is full is discarded, the buffered byte is kept, and `flag_wcol` goes to 1.
- R5: A byte that completes while `rx_valid` is 1 is dropped, `rd_data` keeps the old byte, and `flag_ovr` goes to 1.
- R6: In 4-wire mode (`three_wire`=0) SCK edges are ignored while `ss_n` is 1, and a falling edge of `ss_n` restarts the bit count.
- R7: In 3-wire mode (`three_wire`=1) `ss_n` is ignored, and the bit count restarts only when `enable` is cleared and set again.
- R8: `flag_done`, `flag_wcol` and `flag_ovr` stay at 1 until pulsed by `clr_done`, `clr_wcol` or `clr_ovr`, and `irq` is 1 exactly while `irq_en` is 1 and any flag is 1.
- R9: `miso_oe` is 1 only while `enable` is 1 and, in 4-wire mode, `ss_n` is 0.
- R10: A one-cycle `rd_en` pulse clears `rx_valid`.
- R11: After reset `rx_valid`, all three flags, `irq` and `miso_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; a low level clears the bit counters |
| three_wire | input | 1 | 1 selects 3-wire mode, 0 selects 4-wire mode |
| cpol | input | 1 | Idle level of SCK |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Host write strobe for the transmit byte |
| wr_data | input | 8 | Host transmit byte |
| rd_en | input | 1 | Host read strobe, empties the receive buffer |
| rd_data | output | 8 | Receive buffer contents |
| rx_valid | output | 1 | Receive buffer holds an unread byte |
| clr_done | input | 1 | Clears the byte-complete flag |
| clr_wcol | input | 1 | Clears the write-collision flag |
| clr_ovr | input | 1 | Clears the overrun flag |
| flag_done | output | 1 | Sticky byte-complete flag |
| flag_wcol | output | 1 | Sticky write-collision flag |
| flag_ovr | output | 1 | Sticky receive-overrun flag |
| irq | output | 1 | Interrupt request |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for MISO; 0 models a tri-stated pin |

## Verification
A pin change on SCK, MOSI or select takes effect on the third rising system clock after it: two synchroniser stages and one edge register. The byte-complete flag, the receive data and the next MISO bit are therefore visible after that third edge. Host writes, reads and flag clears act on the edge that captures the strobe. The bench holds each SCK half period for eight system clocks. The master model samples MISO only at its own sampling edge, at least five clocks after the slave's shift edge. Flags and receive data are checked six or more clocks after the last SCK edge, and host-side results on the falling clock edge after the strobe.

// File: rtl/spis_pkg.sv
package spis_pkg;

   typedef struct packed {
      logic done;
      logic wcol;
      logic ovr;
   } spis_flags_t;

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [31:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spis_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stg[i] <= RST_VAL[WIDTH-1:0];
            else if (i == 0)
               stg[i] <= d;
            else
               stg[i] <= stg[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spis_rx.sv
module spis_rx #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          smp,
   input  logic          sdi,
   output logic          done,
   output logic [DW-1:0] byte_o
);

   localparam int CW = $clog2(DW);
   localparam logic [CW-1:0] LAST = CW'(DW-1);

   logic [CW-1:0] cnt;
   logic [DW-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         shreg <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (smp) begin
         shreg <= {shreg[DW-2:0], sdi};
         cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   assign done   = smp && !clr && (cnt == LAST);
   assign byte_o = {shreg[DW-2:0], sdi};

   // R7: a cleared counter never completes a byte on the next sample
   a_r7_clr_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !done);

endmodule

// File: rtl/spis_tx.sv
module spis_tx #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          cpha,
   input  logic          shf,
   input  logic          smp,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic          wcol_ev,
   output logic          sdo
);

   localparam int OW = $clog2(DW+1);
   localparam logic [OW-1:0] OLAST0 = OW'(DW-1);
   localparam logic [OW-1:0] OLAST1 = OW'(DW);

   logic [DW-1:0] txb, sr;
   logic          txb_full, sr_full;
   logic [OW-1:0] ocnt, idx;
   logic          end_ev;

   // last SCK edge of a byte: trailing edge in both phases
   assign end_ev  = cpha ? (smp && ocnt == OLAST1) : (shf && ocnt == OLAST0);
   assign wcol_ev = wr && txb_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txb      <= '0;
         txb_full <= 1'b0;
         sr       <= '0;
         sr_full  <= 1'b0;
      end else begin
         if (wr && !txb_full) begin
            txb      <= wdata;
            txb_full <= 1'b1;
         end
         if (end_ev && !clr) begin
            if (txb_full) begin
               sr       <= txb;
               sr_full  <= 1'b1;
               txb_full <= 1'b0;
            end else begin
               sr_full <= 1'b0;
            end
         end else if (!sr_full && txb_full) begin
            sr       <= txb;
            sr_full  <= 1'b1;
            txb_full <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ocnt <= '0;
      else if (clr)
         ocnt <= '0;
      else if (shf) begin
         if (!cpha)
            ocnt <= (ocnt == OLAST0) ? '0 : ocnt + 1'b1;
         else
            ocnt <= (ocnt == OLAST1) ? OW'(1) : ocnt + 1'b1;
      end
   end

   always_comb begin
      if (!cpha)
         idx = OLAST0 - ocnt;
      else if (ocnt == '0)
         idx = OLAST0;
      else
         idx = OLAST1 - ocnt;
   end

   assign sdo = sr[idx[OW-1:0] < OW'(DW) ? idx : '0];

   // R4: a rejected write leaves the buffered byte untouched
   a_r4_wcol_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && txb_full) |=> $stable(txb));

   // R3: a buffered byte never waits behind an empty shift register
   a_r3_prompt_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_full && txb_full) |=> sr_full);

endmodule

// File: rtl/spi_slave_dbuf.sv
module spi_slave_dbuf
   import spis_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              three_wire,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              irq_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_valid,
   input  logic              clr_done,
   input  logic              clr_wcol,
   input  logic              clr_ovr,
   output logic              flag_done,
   output logic              flag_wcol,
   output logic              flag_ovr,
   output logic              irq,
   input  logic              sck,
   input  logic              ss_n,
   input  logic              mosi,
   output logic              miso,
   output logic              miso_oe
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_slave_dbuf: DATA_W must be at least 2");
      end
   endgenerate

   logic [2:0] pins_s;
   logic       sck_s, mosi_s, ssn_s, sck_q, ssn_q;

   spis_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(32'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ss_n, mosi, sck}), .q(pins_s));

   assign {ssn_s, mosi_s, sck_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         ssn_q <= 1'b1;
      end else begin
         sck_q <= sck_s;
         ssn_q <= ssn_s;
      end
   end

   logic rise, fall, lead, trail, active, smp, shf, clr;

   assign rise   = sck_s && !sck_q;
   assign fall   = !sck_s && sck_q;
   assign lead   = cpol ? fall : rise;
   assign trail  = cpol ? rise : fall;
   assign active = enable && (three_wire || !ssn_s);
   assign smp    = active && (cpha ? trail : lead);
   assign shf    = active && (cpha ? lead : trail);
   assign clr    = !enable || (!three_wire && ssn_q && !ssn_s);

   logic              byte_done, wcol_ev;
   logic [DATA_W-1:0] rx_byte;

   spis_rx #(.DW(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .clr(clr), .smp(smp), .sdi(mosi_s),
      .done(byte_done), .byte_o(rx_byte));

   spis_tx #(.DW(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cpha(cpha), .shf(shf), .smp(smp),
      .wr(wr_en), .wdata(wr_data), .wcol_ev(wcol_ev), .sdo(miso));

   logic [DATA_W-1:0] rxb;
   logic              rxb_full;
   spis_flags_t       flg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxb      <= '0;
         rxb_full <= 1'b0;
         flg      <= '0;
      end else begin
         if (rd_en)
            rxb_full <= 1'b0;
         if (byte_done && !(rxb_full && !rd_en)) begin
            rxb      <= rx_byte;
            rxb_full <= 1'b1;
         end
         flg.done <= (flg.done && !clr_done) || byte_done;
         flg.wcol <= (flg.wcol && !clr_wcol) || wcol_ev;
         flg.ovr  <= (flg.ovr && !clr_ovr) || (byte_done && rxb_full && !rd_en);
      end
   end

   assign rd_data   = rxb;
   assign rx_valid  = rxb_full;
   assign flag_done = flg.done;
   assign flag_wcol = flg.wcol;
   assign flag_ovr  = flg.ovr;
   assign irq       = irq_en && (flg.done || flg.wcol || flg.ovr);
   assign miso_oe   = active;

   // R5: an overrun keeps the unread byte and raises the flag
   a_r5_ovr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && byte_done && !rd_en) |=> (rd_data == $past(rd_data) && flag_ovr));

   // R8: byte-complete flag is sticky until cleared
   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_done && !clr_done) |=> flag_done);

   // R6: no byte completes while deselected in 4-wire mode
   a_r6_no_capture_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      (!three_wire && ssn_s) |-> !byte_done);

   // R10: a read with no new byte leaves the buffer empty
   a_r10_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !byte_done) |=> !rx_valid);

endmodule

// File: tb/sim_spi_slave_dbuf.sv
module sim_spi_slave_dbuf;

   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0, three_wire = 1'b0, cpol = 1'b0, cpha = 1'b0, irq_en = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       rx_valid;
   logic       clr_done = 1'b0, clr_wcol = 1'b0, clr_ovr = 1'b0;
   logic       flag_done, flag_wcol, flag_ovr, irq;
   logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
   logic       miso, miso_oe;

   int         n_chk = 0, n_err = 0;
   bit         auto_rd = 1'b1;
   bit         finished = 1'b0;
   logic [7:0] exp_rx[$];

   always #4 clk = ~clk;

   spi_slave_dbuf u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .three_wire(three_wire),
      .cpol(cpol), .cpha(cpha), .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .rx_valid(rx_valid),
      .clr_done(clr_done), .clr_wcol(clr_wcol), .clr_ovr(clr_ovr),
      .flag_done(flag_done), .flag_wcol(flag_wcol), .flag_ovr(flag_ovr), .irq(irq),
      .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso), .miso_oe(miso_oe));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clocks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_wr(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic clear_all();
      @(negedge clk); clr_done = 1'b1; clr_wcol = 1'b1; clr_ovr = 1'b1;
      @(negedge clk); clr_done = 1'b0; clr_wcol = 1'b0; clr_ovr = 1'b0;
   endtask

   task automatic set_mode(input bit pol, input bit pha, input bit tw);
      @(negedge clk); enable = 1'b0;
      clocks(2);
      cpol = pol; cpha = pha; three_wire = tw; sck = pol;
      clocks(6);
      enable = 1'b1;
      clocks(2);
   endtask

   task automatic sel_lo();
      @(negedge clk); ss_n = 1'b0;
      clocks(5);
   endtask

   task automatic sel_hi();
      clocks(5);
      ss_n = 1'b1;
      clocks(6);
   endtask

   task automatic spi_bits(input int n, input logic [7:0] mo, output logic [7:0] mi);
      mi = '0;
      for (int i = 0; i < n; i++) begin
         if (!cpha) begin
            mosi = mo[7-i];
            clocks(HALF);
            sck = ~cpol; mi[7-i] = miso;
            clocks(HALF);
            sck = cpol;
         end else begin
            clocks(HALF);
            sck = ~cpol; mosi = mo[7-i];
            clocks(HALF);
            sck = cpol; mi[7-i] = miso;
         end
      end
   endtask

   // driver: pushes the expected received byte, then checks MISO itself
   task automatic xfer(input logic [7:0] mo, input bit push, input bit chk,
                       input logic [7:0] exp_mi, input string tag);
      logic [7:0] mi;
      if (push) exp_rx.push_back(mo);
      spi_bits(8, mo, mi);
      if (chk) check(mi == exp_mi, tag, mi, exp_mi);
   endtask

   // monitor: pops the scoreboard whenever the receive buffer fills
   initial begin
      forever begin
         @(negedge clk);
         if (auto_rd && rx_valid) begin
            if (exp_rx.size() == 0)
               check(1'b0, "R1 unexpected byte", rd_data, 0);
            else begin
               logic [7:0] e;
               e = exp_rx.pop_front();
               check(rd_data == e, "R1 received byte", rd_data, e);
            end
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            check(!rx_valid, "R10 read empties buffer", rx_valid, 0);
         end
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] junk;
      clocks(3);
      check(!rx_valid && !flag_done && !flag_wcol && !flag_ovr && !irq && !miso_oe,
            "R11 reset state", {rx_valid, flag_done, flag_wcol, flag_ovr, irq, miso_oe}, 0);
      rst_n = 1'b1;
      clocks(2);
      irq_en = 1'b1;

      // mode 0, 4-wire: basic byte both ways
      set_mode(1'b0, 1'b0, 1'b0);
      check(!miso_oe, "R9 oe low while deselected", miso_oe, 0);
      host_wr(8'hA5);
      clocks(3);
      sel_lo();
      check(miso_oe, "R9 oe high while selected", miso_oe, 1);
      check(miso == 1'b1, "R3 first bit before first edge", miso, 1);
      auto_rd = 1'b0;
      xfer(8'h3C, 1'b1, 1'b1, 8'hA5, "R3 miso byte mode0");
      clocks(6);
      check(flag_done && rx_valid, "R1 done and valid", {flag_done, rx_valid}, 3);
      check(irq, "R8 irq on done", irq, 1);
      auto_rd = 1'b1;
      clocks(4);
      check(flag_done, "R8 flag sticky after read", flag_done, 1);
      sel_hi();
      clear_all();
      check(!flag_done && !irq, "R8 clear drops irq", {flag_done, irq}, 0);

      // remaining clock modes
      for (int m = 1; m < 4; m++) begin
         logic [7:0] tx, rx;
         tx = 8'h1D + 8'(m * 37);
         rx = 8'hC2 ^ 8'(m * 19);
         set_mode(m[1], m[0], 1'b0);
         host_wr(tx);
         clocks(3);
         sel_lo();
         xfer(rx, 1'b1, 1'b1, tx, $sformatf("R2 miso byte mode%0d", m));
         sel_hi();
         check(exp_rx.size() == 0, "R2 byte received in mode", exp_rx.size(), 0);
         clear_all();
      end

      // double buffer and collision, mode 0
      set_mode(1'b0, 1'b0, 1'b0);
      host_wr(8'h81);
      clocks(3);
      host_wr(8'h42);
      host_wr(8'hFF);
      check(flag_wcol, "R4 collision flag", flag_wcol, 1);
      check(irq, "R8 irq on collision", irq, 1);
      sel_lo();
      xfer(8'h5A, 1'b1, 1'b1, 8'h81, "R3 first shifted byte");
      xfer(8'hC3, 1'b1, 1'b1, 8'h42, "R4 buffered byte kept");
      sel_hi();
      irq_en = 1'b0;
      clocks(1);
      check(!irq, "R8 irq masked", irq, 0);
      irq_en = 1'b1;
      clear_all();

      // overrun, mode 1
      set_mode(1'b0, 1'b1, 1'b0);
      auto_rd = 1'b0;
      exp_rx.push_back(8'h11);
      sel_lo();
      xfer(8'h11, 1'b0, 1'b0, 8'h00, "R5");
      xfer(8'h22, 1'b0, 1'b0, 8'h00, "R5");
      sel_hi();
      check(flag_ovr, "R5 overrun flag", flag_ovr, 1);
      check(rd_data == 8'h11, "R5 old byte kept", rd_data, 8'h11);
      auto_rd = 1'b1;
      clocks(6);
      check(exp_rx.size() == 0, "R5 old byte read", exp_rx.size(), 0);
      clear_all();

      // 4-wire select behaviour, mode 0
      set_mode(1'b0, 1'b0, 1'b0);
      spi_bits(3, 8'hFF, junk);
      clocks(6);
      check(!flag_done && !rx_valid, "R6 edges ignored deselected", {flag_done, rx_valid}, 0);
      sel_lo();
      spi_bits(3, 8'hE0, junk);
      sel_hi();
      sel_lo();
      xfer(8'h6B, 1'b1, 1'b0, 8'h00, "R6");
      sel_hi();
      check(exp_rx.size() == 0, "R6 select restarts count", exp_rx.size(), 0);
      clear_all();

      // 3-wire mode, mode 0, select held high
      set_mode(1'b0, 1'b0, 1'b1);
      check(miso_oe, "R9 oe high in 3-wire", miso_oe, 1);
      xfer(8'h96, 1'b1, 1'b0, 8'h00, "R7");
      clocks(8);
      check(exp_rx.size() == 0, "R7 select ignored", exp_rx.size(), 0);
      spi_bits(3, 8'hA0, junk);
      clocks(4);
      @(negedge clk); enable = 1'b0;
      clocks(2);
      enable = 1'b1;
      clocks(2);
      xfer(8'h69, 1'b1, 1'b0, 8'h00, "R7");
      clocks(8);
      check(exp_rx.size() == 0, "R7 enable toggle restarts count", exp_rx.size(), 0);

      clocks(10);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule